// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two 18-bit buses, A and B, and passes data between them without inversion. Each direction has its own storage element, and four controls set how it behaves: a transparent enable, a capture clock, an active-low capture enable and an active-low output enable. When the transparent enable is high, the far bus follows the near bus at once. When it is low, the storage holds its value. It loads a new value only on a rising edge of its capture clock, and only while the capture enable is low.

The two directions share nothing except the system clock and reset. The capture clocks are ordinary inputs. The block samples them on the system clock and detects their rising edges in that clock domain, so each capture clock must stay at each level for at least one system clock cycle.

The block has no tri-state pins. For each bus it gives a data-out vector and a drive flag, and the pad ring builds the tri-state driver from these. When a bus is not driven, its data-out is zero. The last value a bus carried stays on its input side, as a bus keeper would hold it.

Top module: `bus_xcvr_lr`

## Requirements
- R1: Both directions carry WIDTH bits (default 18) without inversion, so all-ones and alternating patterns arrive unchanged.
- R2: While `ab_le` is high and `ab_oe_n` is low, `b_out` equals `a_in` in the same cycle. On each system clock edge during this time, the storage takes in `a_in`.
- R3: A high transparent enable overrides the capture clock and the capture enable. After the enable falls, the held value is the `a_in` sampled at the last system clock edge while the enable was still high.
- R4: While `ab_le` is low and `ab_clken_n` is low, a system clock edge at which `ab_clk` is 1 and was 0 at the previous edge loads `a_in` into the storage. From that edge on, `b_out` shows the loaded value.
- R5: While `ab_le` is low and `ab_clken_n` is high, rising edges on `ab_clk` are ignored and `b_out` keeps the stored value. With no rising edge, the stored value is also kept.
- R6: `ab_oe_n` is active low. When it is high, `b_drive` is 0 and `b_out` is all zeros. When it is low, `b_drive` is 1.
- R7: The B-to-A direction (`ba_*` controls, `b_in` to `a_out`/`a_drive`) obeys R2 to R6 and runs fully independently of the A-to-B direction.
- R8: A synchronous `rst` clears both stores to zero and clears the capture-clock history to 0.
- R9: When both output enables are low, both drive flags are 1 at the same time. This is bus contention, and the bench reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Data for the A bus (zero when not driven) |
| a_drive | output | 1 | Drive enable for the A bus |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Data for the B bus (zero when not driven) |
| b_drive | output | 1 | Drive enable for the B bus |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B transparent enable |
| ab_clk | input | 1 | A-to-B capture clock |
| ab_clken_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A transparent enable |
| ba_clk | input | 1 | B-to-A capture clock |
| ba_clken_n | input | 1 | B-to-A capture enable, active low |

## Verification
A wrong stored value, or a wrong capture-clock history bit, is hidden while the transparent enable is high or the output is off. It shows on the far bus in the first cycle with the transparent enable low and the output enable low. A missed or false capture edge therefore shows on the output one system clock after the edge. A pseudo-random sweep keeps the transparent enable low most of the time and the outputs on most of the time, so the stores are seen almost every cycle. Directed sequences cover reset, enable priority, the independence of the two directions and contention.

// File: rtl/bus_xcvr_lr.sv
module bus_xcvr_lr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_clken_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_clken_n
);

  logic [WIDTH-1:0] ab_store, ba_store;
  logic             ab_clk_q, ba_clk_q;
  logic             ab_edge, ba_edge;

  assign ab_edge = ab_clk & ~ab_clk_q;
  assign ba_edge = ba_clk & ~ba_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_clk_q <= 1'b0;
      ab_store <= '0;
    end else begin
      ab_clk_q <= ab_clk;
      if (ab_le || (!ab_clken_n && ab_edge)) ab_store <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ba_clk_q <= 1'b0;
      ba_store <= '0;
    end else begin
      ba_clk_q <= ba_clk;
      if (ba_le || (!ba_clken_n && ba_edge)) ba_store <= b_in;
    end
  end

  assign b_drive = ~ab_oe_n;
  assign a_drive = ~ba_oe_n;
  assign b_out   = ab_oe_n ? '0 : (ab_le ? a_in : ab_store);
  assign a_out   = ba_oe_n ? '0 : (ba_le ? b_in : ba_store);

  p_transp_ab_r2: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> ab_store == $past(a_in));
  p_transp_ba_r7: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> ba_store == $past(b_in));
  p_capture_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_clken_n && ab_clk && !ab_clk_q) |=> ab_store == $past(a_in));
  p_capture_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !ba_clken_n && ba_clk && !ba_clk_q) |=> ba_store == $past(b_in));
  p_block_ab_r5: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_clken_n) |=> $stable(ab_store));
  p_block_ba_r7: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && ba_clken_n) |=> $stable(ba_store));
  p_clear_ab_r8: assert property (@(posedge clk)
    rst |=> (ab_store == '0 && !ab_clk_q));
  p_clear_ba_r8: assert property (@(posedge clk)
    rst |=> (ba_store == '0 && !ba_clk_q));

endmodule

// File: tb/test_bus_xcvr_lr.sv
`timescale 1ns/1ps
module test_bus_xcvr_lr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_drive, b_drive;
  logic ab_oe_n, ab_le, ab_clk, ab_clken_n;
  logic ba_oe_n, ba_le, ba_clk, ba_clken_n;

  int checks = 0, fails = 0, contentions = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab, m_ba;
  logic m_abq, m_baq;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  bus_xcvr_lr #(.WIDTH(W)) i_bus_xcvr_lr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic string mode_tag(input logic oe_n, input logic le, input logic cen);
    if (oe_n) return "R6";
    if (le) return "R2";
    if (cen) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input string tab, input string tba);
    logic [W:0] e_b, e_a;
    @(posedge clk);
    if (rst) begin
      m_ab = '0; m_ba = '0; m_abq = 1'b0; m_baq = 1'b0;
    end else begin
      if (ab_le || (!ab_clken_n && ab_clk && !m_abq)) m_ab = a_in;
      if (ba_le || (!ba_clken_n && ba_clk && !m_baq)) m_ba = b_in;
      m_abq = ab_clk; m_baq = ba_clk;
    end
    #1;
    e_b = {~ab_oe_n, ab_oe_n ? {W{1'b0}} : (ab_le ? a_in : m_ab)};
    e_a = {~ba_oe_n, ba_oe_n ? {W{1'b0}} : (ba_le ? b_in : m_ba)};
    if (!ab_oe_n && !ba_oe_n) contentions++;
    chk(tab, {b_drive, b_out}, e_b);
    chk(tba, {a_drive, a_out}, e_a);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ab = '0; m_ba = '0; m_abq = 1'b0; m_baq = 1'b0;
    rst = 1'b1; a_in = 18'h15555; b_in = 18'h0F0F0;
    ab_oe_n = 1'b0; ab_le = 1'b0; ab_clk = 1'b0; ab_clken_n = 1'b0;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b0; ba_clken_n = 1'b0;
    @(negedge clk);
    step("R8", "R6");
    ba_oe_n = 1'b0;
    step("R8", "R8");
    rst = 1'b0;
    step("R8", "R8");

    // R1: full-width patterns, one direction enabled at a time
    ab_le = 1'b1; a_in = 18'h3FFFF; ba_oe_n = 1'b1;
    step("R1", "R6");
    a_in = 18'h2AAAA;
    step("R1", "R6");
    ab_oe_n = 1'b1; ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h3FFFF;
    step("R6", "R1");
    b_in = 18'h15555;
    step("R6", "R1");
    ba_le = 1'b0;

    // R3: transparent enable wins over clock and clock enable
    ab_oe_n = 1'b0; ab_le = 1'b1; ab_clken_n = 1'b0; ab_clk = 1'b1; a_in = 18'h01234;
    step("R3", "R5");
    a_in = 18'h2BEEF;
    step("R3", "R5");
    ab_le = 1'b0; a_in = 18'h00777;
    step("R3", "R5");
    ab_clk = 1'b0;
    step("R3", "R5");
    ab_clk = 1'b1;
    step("R4", "R5");

    // R7: B-to-A blocked edges while A-to-B captures
    ba_clken_n = 1'b1; b_in = 18'h3C3C3; ba_clk = 1'b1; ab_clk = 1'b0; a_in = 18'h11111;
    step("R7", "R7");
    ba_clk = 1'b0; ab_clk = 1'b1;
    step("R7", "R7");
    ba_clk = 1'b1; ab_clk = 1'b0;
    step("R7", "R7");

    // R9: both outputs enabled
    $display("note: contention expected, both buses driven");
    step("R9", "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, d;
      seed = nxt(seed); r = seed;
      seed = nxt(seed); d = seed;
      rst = (r[31:25] == 7'd0);
      ab_le = (r[2:0] == 3'd0); ab_clken_n = r[3] & r[4]; ab_clk = r[5];
      ab_oe_n = r[6] & r[7];
      ba_le = (r[10:8] == 3'd0); ba_clken_n = r[11] & r[12]; ba_clk = r[13];
      ba_oe_n = r[14] & r[15];
      if (ba_oe_n) a_in = d[W-1:0];
      if (ab_oe_n) b_in = d[31:32-W];
      if (rst) step("R8", "R8");
      else step(mode_tag(ab_oe_n, ab_le, ab_clken_n), mode_tag(ba_oe_n, ba_le, ba_clken_n));
    end
    rst = 1'b0;

    $display("note: %0d cycles flagged as bus contention (R9)", contentions);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule